// File: doc/BRIEF.md
# Receive Descriptor Scatter Engine

This block takes one received frame at a time from a byte stream and spreads it over a ring of receive descriptors held in shared memory. Each descriptor is two 32-bit words. The word at descriptor address D holds the status flags in bits 31:16 and the byte count in bits 15:0. The word at D+4 holds the address of the descriptor's data buffer. The stream delivers payload bytes, and the 32-bit frame check sequence travels with the final byte. The engine stores the payload internally and adds the four check bytes to it, so the stored length is the payload length plus four.

Before it writes anything, the engine walks the ring from the current descriptor to make sure there are enough empty buffers. If there are not, the frame is discarded and memory is left untouched. If there are, each buffer is written one byte at a time and its descriptor is then updated. The final descriptor of the frame carries the end-of-frame bit and two length-error flags. After the frame, the engine reads the next descriptor to decide whether reception stays open.

The memory port is word-addressed with byte lanes and uses big-endian lane order: byte address A uses bits 31-8*(A mod 4) down to 24-8*(A mod 4). Read data is valid in the cycle after the read strobe. Configuration is written through a small select/data port: select 0 sets the ring start, select 1 sets the buffer size, and select 2 sets the frame length limit.

Top module: `rx_scatter`

## Requirements
- R1: The stream ready output is high only while reception is open. Reception opens when `rx_kick` pulses while `ctl_enable` is high and the current descriptor's empty bit (flag bit 15) is set. A pulse while `ctl_enable` is low, or while that bit is clear, leaves reception closed. No memory access takes place while bytes are being accepted.
- R2: The buffer size keeps only bits 10:4 of the written value. If those bits are all zero, the size becomes 0x7F0. The reset value is 0x7F0.
- R3: The space check starts at the current descriptor and subtracts the buffer size for each empty descriptor it meets, until the remaining length is at most one buffer. If it meets a descriptor whose empty bit is clear before that point, the whole frame is consumed and dropped: no memory write, no event, and reception stays open.
- R4: Each descriptor takes min(remaining, buffer size) bytes and records that count in its length field. The total is the payload length plus 4.
- R5: The four check bytes follow the payload, most significant byte first, and continue into the next buffer when the current one fills.
- R6: Every descriptor that is used has its empty bit cleared, and its other flag bits are kept. The final descriptor also gets bit 11 and the error flags, and raises `ev_rxf`. Each earlier descriptor raises `ev_rxb`. Each event lasts one cycle and coincides with the descriptor write.
- R7: A total longer than 2032 bytes is cut to 2032 bytes: 2028 payload bytes followed by the check bytes. Flag bits 0 and 5 are set.
- R8: A total larger than the length limit sets flag bit 5 only. The limit resets to 0x05EE (1518).
- R9: After a descriptor is used, if its flag bit 13 is set the next descriptor is the ring start. Otherwise the next descriptor is at the current address plus 8.
- R10: After a frame completes, reception stays open only if the next descriptor's empty bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ctl_enable | input | 1 | Controller enable; when low, reception closes between frames |
| rx_kick | input | 1 | Receive-activate pulse |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | 0 ring start, 1 buffer size, 2 length limit |
| cfg_wdata | input | 32 | Configuration write data |
| in_valid | input | 1 | Stream byte valid |
| in_ready | output | 1 | Stream byte accepted when high with `in_valid` |
| in_data | input | 8 | Stream payload byte |
| in_last | input | 1 | Marks the final payload byte |
| in_fcs | input | 32 | Check sequence, sampled with the final byte |
| mem_re | output | 1 | Memory read strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | AW | Word-aligned memory address |
| mem_wstrb | output | 4 | Byte-lane enables, bit 3 = lane at offset 0 |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Read data, one cycle after `mem_re` |
| ev_rxf | output | 1 | Frame-complete event |
| ev_rxb | output | 1 | Buffer-complete event |

## Verification
A configuration write can land in the same cycle that the final byte of a frame is accepted. In that case the new value must govern the frame that is closing. The bench forces this by writing a lower length limit (80) together with the final byte of a 94-byte total. It then expects flag bit 5 in the last descriptor's write-back, and a scoreboard compares every memory write against the bench's own ring model. A drop and a completion can never overlap because the ring walk always finishes before the first data write.

// File: rtl/rx_scatter.sv
module rx_scatter #(
  parameter int AW        = 32,
  parameter int FRAME_MAX = 2032,
  parameter int LW        = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_enable,
  input  logic          rx_kick,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [31:0]   cfg_wdata,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [7:0]    in_data,
  input  logic          in_last,
  input  logic [31:0]   in_fcs,
  output logic          mem_re,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [3:0]    mem_wstrb,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  output logic          ev_rxf,
  output logic          ev_rxb
);
  localparam int PAY_MAX = FRAME_MAX - 4;
  localparam int IW      = $clog2(PAY_MAX);

  typedef enum logic [3:0] {
    S_FILL, S_START, S_WALK_RD, S_WALK_CHK, S_D0_RD, S_D1_RD,
    S_D1_CAP, S_DATA, S_WB, S_EN_RD, S_EN_CAP
  } st_t;

  st_t           st;
  logic          rx_on, over, lg, tr;
  logic [AW-1:0] base, cur, walk, bufptr, baddr;
  logic [10:0]   bufsz;
  logic [LW-1:0] maxlen, cnt, want, remain, pos, plen, chunk, boff, tot, bsz;
  logic [15:0]   flags, newflags;
  logic [31:0]   fcs;
  logic [7:0]    pay [PAY_MAX];
  logic [7:0]    obyte, fbyte;
  logic [1:0]    fk;
  logic          last_c;

  assign bsz      = LW'(bufsz);
  assign tot      = over ? LW'(FRAME_MAX) : cnt + LW'(4);
  assign in_ready = (st == S_FILL) && rx_on;
  assign baddr    = bufptr + AW'(boff);
  assign fk       = pos[1:0] - plen[1:0];
  assign last_c   = (remain == chunk);
  assign newflags = (flags & 16'h7FFF) | (last_c ? {4'b0, 1'b1, 5'b0, lg, 4'b0, tr} : 16'h0);

  always_comb begin
    case (fk)
      2'd0:    fbyte = fcs[31:24];
      2'd1:    fbyte = fcs[23:16];
      2'd2:    fbyte = fcs[15:8];
      default: fbyte = fcs[7:0];
    endcase
    obyte = (pos < plen) ? pay[pos[IW-1:0]] : fbyte;
  end

  always_ff @(posedge clk)
    if (st == S_FILL && in_valid && in_ready && cnt < LW'(PAY_MAX))
      pay[cnt[IW-1:0]] <= in_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_FILL; rx_on <= 1'b0; over <= 1'b0; lg <= 1'b0; tr <= 1'b0;
      base <= '0; cur <= '0; walk <= '0; bufptr <= '0;
      bufsz <= 11'h7F0; maxlen <= LW'(16'h05EE);
      cnt <= '0; want <= '0; remain <= '0; pos <= '0; plen <= '0;
      chunk <= '0; boff <= '0; flags <= '0; fcs <= '0;
    end else begin
      if (cfg_we) begin
        case (cfg_sel)
          2'd0: begin
            base <= cfg_wdata[AW-1:0] & ~AW'(3);
            cur  <= cfg_wdata[AW-1:0] & ~AW'(3);
          end
          2'd1: bufsz <= (cfg_wdata[10:4] == 7'd0) ? 11'h7F0 : {cfg_wdata[10:4], 4'b0};
          2'd2: maxlen <= cfg_wdata[LW-1:0];
          default: ;
        endcase
      end
      case (st)
        S_FILL: begin
          if (in_valid && in_ready) begin
            if (cnt < LW'(PAY_MAX)) cnt <= cnt + 1'b1;
            else over <= 1'b1;
            if (in_last) begin
              fcs <= in_fcs;
              st  <= S_START;
            end
          end else if (!rx_on && rx_kick && ctl_enable) begin
            st <= S_EN_RD;
          end else if (!ctl_enable && cnt == '0) begin
            rx_on <= 1'b0;
          end
        end
        S_START: begin
          want   <= tot;
          remain <= tot;
          plen   <= tot - LW'(4);
          pos    <= '0;
          tr     <= over;
          lg     <= over || (tot > maxlen);
          walk   <= cur;
          st     <= S_WALK_RD;
        end
        S_WALK_RD: st <= S_WALK_CHK;
        S_WALK_CHK: begin
          if (!mem_rdata[31]) begin
            cnt  <= '0;
            over <= 1'b0;
            st   <= S_FILL;
          end else if (want <= bsz) begin
            st <= S_D0_RD;
          end else begin
            want <= want - bsz;
            walk <= mem_rdata[29] ? base : walk + AW'(8);
            st   <= S_WALK_RD;
          end
        end
        S_D0_RD: st <= S_D1_RD;
        S_D1_RD: begin
          flags <= mem_rdata[31:16];
          st    <= S_D1_CAP;
        end
        S_D1_CAP: begin
          bufptr <= mem_rdata[AW-1:0];
          chunk  <= (remain < bsz) ? remain : bsz;
          boff   <= '0;
          st     <= S_DATA;
        end
        S_DATA: begin
          boff <= boff + 1'b1;
          pos  <= pos + 1'b1;
          if (boff == chunk - 1'b1) st <= S_WB;
        end
        S_WB: begin
          remain <= remain - chunk;
          cur    <= flags[13] ? base : cur + AW'(8);
          if (last_c) begin
            cnt  <= '0;
            over <= 1'b0;
            st   <= S_EN_RD;
          end else begin
            st <= S_D0_RD;
          end
        end
        S_EN_RD: st <= S_EN_CAP;
        S_EN_CAP: begin
          rx_on <= mem_rdata[31] && ctl_enable;
          st    <= S_FILL;
        end
        default: st <= S_FILL;
      endcase
    end
  end

  always_comb begin
    mem_re = 1'b0; mem_we = 1'b0; mem_addr = '0; mem_wstrb = 4'b0;
    mem_wdata = '0; ev_rxf = 1'b0; ev_rxb = 1'b0;
    case (st)
      S_WALK_RD: begin mem_re = 1'b1; mem_addr = walk; end
      S_D0_RD:   begin mem_re = 1'b1; mem_addr = cur; end
      S_D1_RD:   begin mem_re = 1'b1; mem_addr = cur + AW'(4); end
      S_EN_RD:   begin mem_re = 1'b1; mem_addr = cur; end
      S_DATA: begin
        mem_we    = 1'b1;
        mem_addr  = {baddr[AW-1:2], 2'b00};
        mem_wstrb = 4'b1000 >> baddr[1:0];
        mem_wdata = {4{obyte}};
      end
      S_WB: begin
        mem_we    = 1'b1;
        mem_addr  = cur;
        mem_wstrb = 4'hF;
        mem_wdata = {newflags, chunk[15:0]};
        ev_rxf    = last_c;
        ev_rxb    = !last_c;
      end
      default: ;
    endcase
  end

  assert_quiet_fill_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (!mem_we && !mem_re));
  assert_bufsz_shape_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bufsz[3:0] == 4'd0) && (bufsz != 11'd0));
  assert_no_rw_clash_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));
  assert_len_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rxf || ev_rxb) |-> (mem_wdata[15:0] != 16'd0 && LW'(mem_wdata[15:0]) <= bsz));
  assert_event_writeback_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rxf || ev_rxb) |-> (mem_we && mem_wstrb == 4'hF && !mem_wdata[31]));
  assert_last_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rxf |-> mem_wdata[27]);
  assert_mid_clean_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rxb |-> (!mem_wdata[27] && !mem_wdata[21] && !mem_wdata[16]));
  assert_trunc_long_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rxf && mem_wdata[16]) |-> mem_wdata[21]);
endmodule

// File: tb/test_rx_scatter.sv
module test_rx_scatter;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ctl_enable = 1'b0, rx_kick = 1'b0, cfg_we = 1'b0;
  logic [1:0] cfg_sel = 2'd0;
  logic [31:0] cfg_wdata = '0;
  logic in_valid = 1'b0, in_last = 1'b0, in_ready;
  logic [7:0] in_data = '0;
  logic [31:0] in_fcs = '0;
  logic mem_re, mem_we, ev_rxf, ev_rxb;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0] mem_wstrb;

  always #5 clk = ~clk;

  rx_scatter i_rx_scatter (.*);

  logic [31:0] mem [4096];
  logic bd_we = 1'b0;
  logic [31:0] bd_a = '0, bd_d = '0;
  always @(posedge clk) begin
    if (bd_we) mem[bd_a[13:2]] <= bd_d;
    if (mem_we)
      for (int l = 0; l < 4; l++)
        if (mem_wstrb[l]) mem[mem_addr[13:2]][8*l +: 8] <= mem_wdata[8*l +: 8];
    if (mem_re) mem_rdata <= mem[mem_addr[13:2]];
  end

  typedef struct { logic [31:0] a; logic [3:0] s; logic [31:0] d; logic [1:0] ev; string req; } exp_t;
  exp_t q[$];
  int checks = 0, errors = 0;
  int bsz = 2032, maxl = 1518, mcur = 0;
  bit me [4];
  localparam logic [31:0] BASE = 32'h100;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pb(int i, int seed);
    return 8'((i * 7 + seed) & 255);
  endfunction

  always @(negedge clk) if (rst_n) begin
    if (mem_we) begin
      if (q.size() == 0) chk(0, "R3 unexpected write", mem_addr, 32'h0);
      else begin
        exp_t e;
        logic [31:0] m;
        e = q.pop_front();
        m = {{8{e.s[3]}}, {8{e.s[2]}}, {8{e.s[1]}}, {8{e.s[0]}}};
        chk(mem_addr == e.a, {e.req, " addr"}, mem_addr, e.a);
        chk(mem_wstrb == e.s, {e.req, " strobe"}, 32'(mem_wstrb), 32'(e.s));
        chk((mem_wdata & m) == (e.d & m), {e.req, " data"}, mem_wdata & m, e.d & m);
        chk({ev_rxf, ev_rxb} == e.ev, "R6 event", 32'({ev_rxf, ev_rxb}), 32'(e.ev));
      end
    end else if (ev_rxf || ev_rxb) chk(0, "R6 stray event", 32'({ev_rxf, ev_rxb}), 32'h0);
  end

  task automatic bdw(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk); bd_we = 1'b1; bd_a = a; bd_d = d;
    @(negedge clk); bd_we = 1'b0;
  endtask

  task automatic set_desc(int k, bit e);
    bdw(BASE + 32'(8 * k), {(e ? 16'h8000 : 16'h0) | (k == 3 ? 16'h2000 : 16'h0), 16'h0});
    bdw(BASE + 32'(8 * k) + 4, 32'h400 + 32'(k * 32'h800));
    me[k] = e;
  endtask

  task automatic refill();
    for (int k = 0; k < 4; k++) set_desc(k, 1'b1);
  endtask

  task automatic cfg(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic kick();
    @(negedge clk); rx_kick = 1'b1;
    @(negedge clk); rx_kick = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  function automatic bit build(int n, logic [31:0] f, int seed);
    int tot, plen, w, k, rem, pos, ch;
    bit tr, lg;
    tot = n + 4; tr = 0;
    if (tot > 2032) begin tot = 2032; tr = 1; end
    lg = tr || (tot > maxl);
    plen = tot - 4;
    w = tot; k = mcur;
    forever begin
      if (!me[k]) return 0;
      if (w <= bsz) break;
      w -= bsz; k = (k + 1) % 4;
    end
    rem = tot; pos = 0; k = mcur;
    while (rem > 0) begin
      logic [15:0] fl;
      ch = (rem < bsz) ? rem : bsz;
      for (int j = 0; j < ch; j++) begin
        logic [31:0] a;
        logic [7:0] b;
        exp_t e;
        a = 32'h400 + 32'(k * 32'h800) + 32'(j);
        b = (pos < plen) ? pb(pos, seed) : f[31 - 8 * (pos - plen) -: 8];
        e.a = {a[31:2], 2'b00}; e.s = 4'b1000 >> a[1:0]; e.d = {4{b}}; e.ev = 2'b00;
        e.req = (pos < plen) ? "R4 payload" : "R5 check byte";
        q.push_back(e);
        pos++;
      end
      fl = (k == 3) ? 16'h2000 : 16'h0;
      if (rem == ch) fl = fl | 16'h0800 | (lg ? 16'h0020 : 16'h0) | (tr ? 16'h0001 : 16'h0);
      begin
        exp_t e;
        e.a = BASE + 32'(8 * k); e.s = 4'hF; e.d = {fl, 16'(ch)};
        e.ev = (rem == ch) ? 2'b10 : 2'b01;
        e.req = tr ? "R7 descriptor" : (lg ? "R8 descriptor" : "R6 descriptor");
        q.push_back(e);
      end
      me[k] = 0; rem -= ch;
      k = (k == 3) ? 0 : k + 1;
    end
    mcur = k;
    return 1;
  endfunction

  task automatic send(int n, logic [31:0] f, int seed, bit cfg_on_last, logic [31:0] cval);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      in_valid = 1'b1; in_data = pb(i, seed); in_last = (i == n - 1); in_fcs = f;
      if (cfg_on_last && i == n - 1) begin cfg_we = 1'b1; cfg_sel = 2'd2; cfg_wdata = cval; end
    end
    @(negedge clk); in_valid = 1'b0; in_last = 1'b0; cfg_we = 1'b0;
  endtask

  task automatic frame(int n, logic [31:0] f, int seed, bit cfg_on_last = 0, logic [31:0] cval = 0);
    bit fit;
    fit = build(n, f, seed);
    send(n, f, seed, cfg_on_last, cval);
    if (fit) begin
      while (q.size() != 0) @(negedge clk);
      repeat (6) @(negedge clk);
      chk(in_ready == me[mcur], "R10 reopen", 32'(in_ready), 32'(me[mcur]));
    end else begin
      repeat (20) @(negedge clk);
      chk(q.size() == 0, "R3 queue", 32'(q.size()), 32'h0);
      chk(in_ready == 1'b1, "R3 still open", 32'(in_ready), 32'h1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog", 32'h0, 32'h1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(in_ready == 1'b0, "R1 reset ready", 32'(in_ready), 32'h0);
    chk(!mem_we && !mem_re && !ev_rxf && !ev_rxb, "R1 reset quiet", 32'(mem_we), 32'h0);
    rst_n = 1'b1;
    refill();
    set_desc(0, 1'b0);
    cfg(2'd0, BASE);
    cfg(2'd1, 32'h47); bsz = 64;
    kick();
    chk(in_ready == 1'b0, "R1 kick while disabled", 32'(in_ready), 32'h0);
    ctl_enable = 1'b1;
    kick();
    chk(in_ready == 1'b0, "R1 kick on full descriptor", 32'(in_ready), 32'h0);
    set_desc(0, 1'b1);
    kick();
    chk(in_ready == 1'b1, "R1 kick opens", 32'(in_ready), 32'h1);
    frame(100, 32'hA1B2C3D4, 3);
    set_desc(0, 1'b1); set_desc(1, 1'b1);
    frame(62, 32'h11223344, 9);
    chk(mcur == 0, "R9 wrap", 32'(mcur), 32'h0);
    frame(60, 32'hDEADBEEF, 1);
    frame(100, 32'h55667788, 5);
    frame(20, 32'h0F1E2D3C, 2);
    chk(in_ready == 1'b0, "R10 closes", 32'(in_ready), 32'h0);
    refill();
    kick();
    cfg(2'd1, 32'h0); bsz = 2032;
    frame(1514, 32'h01020304, 4);
    frame(1520, 32'h05060708, 6);
    frame(2100, 32'hCAFEF00D, 8);
    refill();
    kick();
    cfg(2'd1, 32'h4C); bsz = 64;
    maxl = 80;
    frame(90, 32'h9ABCDEF0, 7, 1'b1, 32'd80);
    chk(q.size() == 0, "R4 all writes seen", 32'(q.size()), 32'h0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule